// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This block connects a processor's memory-mapped bus window to the register port of an ATA task-file device. The host issues single-cycle requests carrying an address, an access size, a write flag and write data. The bridge takes a register index from the middle bits of the address. Registers are spaced sixteen bytes apart, so the low four address bits and everything above bit 11 are ignored. Each request becomes zero, one or two strobes on the device side, using a compact select code.

Byte accesses reach the seven task-file registers and the control slot. The control slot is reachable at two indices: a write there sets device control, and a read returns the alternate status. Halfword and word accesses reach only the data port. Every other combination touches nothing and, on a read, returns all ones of the access width. A mode input lets a big-endian host see data-port traffic in its own byte order. Every request is answered by a single ready pulse one cycle later.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The register index is address bits [11:4]; changing bits [3:0] or bits above 11 never changes which register is reached or the data returned.
- R2: A byte access (size code 0) at index 1 to 7 issues one strobe with select equal to the index; a write carries the host's wdata[7:0] on device data [7:0]; a read returns device data [7:0] in rdata[7:0] with rdata[31:8] zero.
- R3: A byte access at index 8 or index 22 issues one strobe on select 8 (control slot); a write sets the device-control register; a read returns the alternate status without the side effect of a status read (select 7).
- R4: A byte read at any other index returns 0x000000FF and issues no strobe; a byte write there issues no strobe.
- R5: Halfword (size code 1) and word (size code 2) accesses at any index other than 0 issue no strobe; such reads return 0x0000FFFF and 0xFFFFFFFF. Size code 3 issues no strobe and reads 0xFFFFFFFF.
- R6: A halfword access at index 0 issues one data-port strobe (select 0) carrying 16 bits in wdata[15:0] or rdata[15:0], with rdata[31:16] zero.
- R7: A word access at index 0 issues two data-port strobes in consecutive cycles. The first, in the request cycle, carries bits [15:0]; the second carries bits [31:16].
- R8: With host_be high at the request, halfword data-port data has its two bytes exchanged, and word data-port data has all four bytes reversed, in both directions.
- R9: ready is high for exactly one cycle, the cycle after each request; rdata is valid in that cycle and zero in every other cycle. A write returns zero data.
- R10: While rst_n is low no strobe is issued and ready stays low. A request coinciding with reset, including the second half of a word, is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Single-cycle access request |
| addr | input | 32 | Byte address of the access |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| we | input | 1 | 1 write, 0 read |
| wdata | input | 32 | Write data, right-aligned |
| host_be | input | 1 | Byte-swap data-port traffic for a big-endian host |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data, valid with ready |
| dev_sel | output | 4 | Device register: 0 data, 1 to 7 task file, 8 control/alternate status |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 16 | Data to the device |
| dev_rdata | input | 16 | Data from the device, valid while dev_rd is high |

## Verification
The low or only device strobe arrives in the request cycle, and the device sees it at the next rising edge. The second half of a word arrives one cycle later, together with ready and the read data. The bench drives each request at a falling edge and samples ready and rdata at the next falling edge. It compares the device stub's register state, write log and strobe count at the falling edge after that, once both strobe edges have passed. At that same point it checks that ready has dropped and rdata has returned to zero. Each data-port write is logged with its cycle number, so the order of the two word halves and the gap between them are checked directly.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_DATA = 2'd1,
      TGT_TASK = 2'd2,
      TGT_CTRL = 2'd3
   } acc_target_e;

   typedef enum logic [2:0] {
      RSP_WRITE   = 3'd0,
      RSP_BYTE    = 3'd1,
      RSP_BYTE_FF = 3'd2,
      RSP_HALF    = 3'd3,
      RSP_HALF_FF = 3'd4,
      RSP_WORD    = 3'd5,
      RSP_WORD_FF = 3'd6
   } rsp_kind_e;

   localparam int SEL_W    = 4;
   localparam int DATA_SEL = 0;
   localparam int CTRL_SEL = 8;

endpackage

// File: rtl/atab_lane_swap.sv
module atab_lane_swap #(
   parameter int W = 16
) (
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int LANES = W / 8;

   if ((W % 8) != 0 || W < 8) begin : g_bad_width
      $error("atab_lane_swap: W must be a positive multiple of 8");
   end

   logic [W-1:0] rev;

   if (LANES == 1) begin : g_single
      assign rev = d;
   end else begin : g_multi
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign rev[8*i +: 8] = d[8*(LANES-1-i) +: 8];
      end
   end

   assign q = en ? rev : d;

endmodule

// File: rtl/atab_decode.sv
module atab_decode
   import ata_bridge_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int IDX_LO     = 4,
   parameter int IDX_HI     = 11,
   parameter int DATA_IDX   = 0,
   parameter int TASK_FIRST = 1,
   parameter int TASK_LAST  = 7,
   parameter int CTRL_IDX_A = 8,
   parameter int CTRL_IDX_B = 22
) (
   input  logic [ADDR_W-1:0] addr,
   input  acc_size_e         size,
   output acc_target_e       tgt,
   output logic [SEL_W-1:0]  sel
);
   localparam int IDX_W = IDX_HI - IDX_LO + 1;

   if (IDX_HI >= ADDR_W || IDX_HI < IDX_LO) begin : g_bad_idx
      $error("atab_decode: index field outside the address");
   end
   if (TASK_LAST >= (1 << SEL_W) || TASK_FIRST > TASK_LAST) begin : g_bad_task
      $error("atab_decode: task-file range does not fit the select code");
   end

   logic [IDX_W-1:0] idx;
   logic             is_task;
   logic             is_ctrl;
   logic             is_data;

   assign idx     = addr[IDX_HI:IDX_LO];
   assign is_task = (int'(idx) >= TASK_FIRST) && (int'(idx) <= TASK_LAST);
   assign is_ctrl = (int'(idx) == CTRL_IDX_A) || (int'(idx) == CTRL_IDX_B);
   assign is_data = (int'(idx) == DATA_IDX);

   always_comb begin
      tgt = TGT_NONE;
      sel = SEL_W'(DATA_SEL);
      unique case (size)
         SZ_BYTE: begin
            if (is_task) begin
               tgt = TGT_TASK;
               sel = idx[SEL_W-1:0];
            end else if (is_ctrl) begin
               tgt = TGT_CTRL;
               sel = SEL_W'(CTRL_SEL);
            end
         end
         SZ_HALF, SZ_WORD: begin
            if (is_data) begin
               tgt = TGT_DATA;
            end
         end
         default: begin
            tgt = TGT_NONE;
         end
      endcase
   end

endmodule

// File: rtl/atab_sequencer.sv
module atab_sequencer
   import ata_bridge_pkg::*;
#(
   parameter int DEV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             we,
   input  acc_size_e        size,
   input  acc_target_e      tgt,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             be,
   input  logic [DEV_W-1:0] lo_wdata,
   input  logic [DEV_W-1:0] hi_wdata,
   input  logic [DEV_W-1:0] dev_rdata,
   output logic             ready,
   output rsp_kind_e        rsp_kind,
   output logic             rsp_be,
   output logic [DEV_W-1:0] lo_cap,
   output logic [SEL_W-1:0] dev_sel,
   output logic             dev_rd,
   output logic             dev_wr,
   output logic [DEV_W-1:0] dev_wdata
);
   logic             ready_q;
   logic             pend_hi;
   logic             pend_we;
   logic [DEV_W-1:0] hi_q;
   rsp_kind_e        kind_d;
   logic             mapped;
   logic             word_data;

   assign mapped    = (tgt != TGT_NONE);
   assign word_data = (size == SZ_WORD) && (tgt == TGT_DATA);

   always_comb begin
      if (we) begin
         kind_d = RSP_WRITE;
      end else begin
         unique case (size)
            SZ_BYTE: kind_d = mapped ? RSP_BYTE : RSP_BYTE_FF;
            SZ_HALF: kind_d = mapped ? RSP_HALF : RSP_HALF_FF;
            SZ_WORD: kind_d = mapped ? RSP_WORD : RSP_WORD_FF;
            default: kind_d = RSP_WORD_FF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q  <= 1'b0;
         pend_hi  <= 1'b0;
         pend_we  <= 1'b0;
         hi_q     <= '0;
         rsp_kind <= RSP_WRITE;
         rsp_be   <= 1'b0;
         lo_cap   <= '0;
      end else begin
         ready_q <= req;
         pend_hi <= req && word_data;
         if (req) begin
            pend_we  <= we;
            hi_q     <= hi_wdata;
            rsp_kind <= kind_d;
            rsp_be   <= be;
            if (!we) begin
               lo_cap <= dev_rdata;
            end
         end
      end
   end

   // pending second half takes the port; the host keeps req low meanwhile
   always_comb begin
      if (pend_hi) begin
         dev_sel   = SEL_W'(DATA_SEL);
         dev_rd    = rst_n && !pend_we;
         dev_wr    = rst_n && pend_we;
         dev_wdata = hi_q;
      end else begin
         dev_sel   = sel_in;
         dev_rd    = rst_n && req && mapped && !we;
         dev_wr    = rst_n && req && mapped && we;
         dev_wdata = lo_wdata;
      end
   end

   assign ready = ready_q;

   // R9: completion pulse one cycle after every request
   a_r9_ready_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ready);
   a_r9_ready_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> $past(req));
   // R7: a data-port word yields a second data-port strobe next cycle
   a_r7_second_half: assert property (@(posedge clk) disable iff (!rst_n)
      (req && word_data) |=> ((dev_rd || dev_wr) && dev_sel == SEL_W'(DATA_SEL)));
   a_r7_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_rd && dev_wr));
   // R10: nothing reaches the device while reset is held
   a_r10_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |-> !(dev_rd || dev_wr || ready));
   // R7: host keeps one access in flight
   a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      pend_hi |-> !req);

endmodule

// File: rtl/mmio_ata_bridge.sv
module mmio_ata_bridge
   import ata_bridge_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DEV_W      = 16,
   parameter int IDX_LO     = 4,
   parameter int IDX_HI     = 11,
   parameter int DATA_IDX   = 0,
   parameter int TASK_FIRST = 1,
   parameter int TASK_LAST  = 7,
   parameter int CTRL_IDX_A = 8,
   parameter int CTRL_IDX_B = 22,
   localparam int BUS_W     = 2 * DEV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              we,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              host_be,
   output logic              ready,
   output logic [BUS_W-1:0]  rdata,
   output logic [3:0]        dev_sel,
   output logic              dev_rd,
   output logic              dev_wr,
   output logic [DEV_W-1:0]  dev_wdata,
   input  logic [DEV_W-1:0]  dev_rdata
);
   localparam logic [BUS_W-1:0] ONES_BYTE = BUS_W'(8'hFF);
   localparam logic [BUS_W-1:0] ONES_HALF = BUS_W'({DEV_W{1'b1}});
   localparam logic [BUS_W-1:0] ONES_WORD = {BUS_W{1'b1}};

   if (DEV_W < 16 || (DEV_W % 8) != 0) begin : g_bad_dev
      $error("mmio_ata_bridge: DEV_W must be a multiple of 8, at least 16");
   end
   if (SEL_W != 4) begin : g_bad_sel
      $error("mmio_ata_bridge: select port is four bits wide");
   end

   acc_size_e        size_e;
   acc_target_e      tgt;
   logic [SEL_W-1:0] sel_dec;
   logic [DEV_W-1:0] half_w_sw;
   logic [BUS_W-1:0] word_w_sw;
   logic [DEV_W-1:0] lo_wdata;
   rsp_kind_e        rsp_kind;
   logic             rsp_be;
   logic [DEV_W-1:0] lo_cap;
   logic [DEV_W-1:0] half_r_sw;
   logic [BUS_W-1:0] word_r_sw;

   assign size_e = acc_size_e'(size);

   atab_decode #(
      .ADDR_W     (ADDR_W),
      .IDX_LO     (IDX_LO),
      .IDX_HI     (IDX_HI),
      .DATA_IDX   (DATA_IDX),
      .TASK_FIRST (TASK_FIRST),
      .TASK_LAST  (TASK_LAST),
      .CTRL_IDX_A (CTRL_IDX_A),
      .CTRL_IDX_B (CTRL_IDX_B)
   ) decode_i (
      .addr (addr),
      .size (size_e),
      .tgt  (tgt),
      .sel  (sel_dec)
   );

   atab_lane_swap #(.W(DEV_W)) wr_half_swap_i (
      .en (host_be),
      .d  (wdata[DEV_W-1:0]),
      .q  (half_w_sw)
   );

   atab_lane_swap #(.W(BUS_W)) wr_word_swap_i (
      .en (host_be),
      .d  (wdata),
      .q  (word_w_sw)
   );

   always_comb begin
      unique case (size_e)
         SZ_BYTE: lo_wdata = DEV_W'(wdata[7:0]);
         SZ_HALF: lo_wdata = half_w_sw;
         default: lo_wdata = word_w_sw[DEV_W-1:0];
      endcase
   end

   atab_sequencer #(.DEV_W(DEV_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .we        (we),
      .size      (size_e),
      .tgt       (tgt),
      .sel_in    (sel_dec),
      .be        (host_be),
      .lo_wdata  (lo_wdata),
      .hi_wdata  (word_w_sw[BUS_W-1:DEV_W]),
      .dev_rdata (dev_rdata),
      .ready     (ready),
      .rsp_kind  (rsp_kind),
      .rsp_be    (rsp_be),
      .lo_cap    (lo_cap),
      .dev_sel   (dev_sel),
      .dev_rd    (dev_rd),
      .dev_wr    (dev_wr),
      .dev_wdata (dev_wdata)
   );

   atab_lane_swap #(.W(DEV_W)) rd_half_swap_i (
      .en (rsp_be),
      .d  (lo_cap),
      .q  (half_r_sw)
   );

   atab_lane_swap #(.W(BUS_W)) rd_word_swap_i (
      .en (rsp_be),
      .d  ({dev_rdata, lo_cap}),
      .q  (word_r_sw)
   );

   always_comb begin
      rdata = '0;
      if (ready) begin
         unique case (rsp_kind)
            RSP_BYTE:    rdata = BUS_W'(lo_cap[7:0]);
            RSP_BYTE_FF: rdata = ONES_BYTE;
            RSP_HALF:    rdata = BUS_W'(half_r_sw);
            RSP_HALF_FF: rdata = ONES_HALF;
            RSP_WORD:    rdata = word_r_sw;
            RSP_WORD_FF: rdata = ONES_WORD;
            default:     rdata = '0;
         endcase
      end
   end

   // R4: unmapped byte read answers with one byte of ones
   a_r4_unmapped_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && size_e == SZ_BYTE && tgt == TGT_NONE) |=> (rdata == ONES_BYTE));
   // R5: wide access away from the data port is never forwarded
   a_r5_wide_off_port: assert property (@(posedge clk) disable iff (!rst_n)
      (req && size_e != SZ_BYTE && tgt == TGT_NONE) |-> !(dev_rd || dev_wr));
   // R9: read data is zero outside the ready pulse
   a_r9_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (rdata == '0));

endmodule

// File: tb/mmio_ata_bridge_tb_top.sv
`timescale 1ns/1ps
module mmio_ata_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [31:0] addr = '0;
   logic [1:0]  size = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic        host_be = 1'b0;
   logic        ready;
   logic [31:0] rdata;
   logic [3:0]  dev_sel;
   logic        dev_rd;
   logic        dev_wr;
   logic [15:0] dev_wdata;
   logic [15:0] dev_rdata;

   always #2 clk = ~clk;

   mmio_ata_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .size(size), .we(we),
      .wdata(wdata), .host_be(host_be), .ready(ready), .rdata(rdata),
      .dev_sel(dev_sel), .dev_rd(dev_rd), .dev_wr(dev_wr),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   // ---------------- device stub ----------------
   logic [7:0]  tf [1:7];
   logic [7:0]  devctl;
   int          rd_cnt, stat_rd, wlog_n, strobes, rst_strobes, cyc;
   logic [15:0] wlog_d [0:63];
   int          wlog_c [0:63];

   function automatic logic [15:0] dval(int c);
      return 16'(32'hC35A + c * 32'h0137);
   endfunction

   always_comb begin
      if (dev_sel == 4'd0)                   dev_rdata = dval(rd_cnt);
      else if (dev_sel >= 4'd1 && dev_sel <= 4'd7) dev_rdata = {8'h00, tf[dev_sel[2:0]]};
      else if (dev_sel == 4'd8)              dev_rdata = {8'h00, tf[7]};
      else                                   dev_rdata = 16'hDEAD;
   end

   initial begin
      for (int i = 1; i <= 7; i++) tf[i] = 8'(8'h10 * i + i);
      devctl = 8'h00; rd_cnt = 0; stat_rd = 0; wlog_n = 0; strobes = 0;
      rst_strobes = 0; cyc = 0;
   end

   always @(posedge clk) begin
      cyc++;
      if (dev_rd || dev_wr) begin
         strobes++;
         if (!rst_n) rst_strobes++;
      end
      if (dev_wr) begin
         if (dev_sel == 4'd0) begin
            if (wlog_n < 64) begin wlog_d[wlog_n] = dev_wdata; wlog_c[wlog_n] = cyc; end
            wlog_n++;
         end else if (dev_sel >= 4'd1 && dev_sel <= 4'd7) tf[dev_sel[2:0]] = dev_wdata[7:0];
         else if (dev_sel == 4'd8) devctl = dev_wdata[7:0];
      end
      if (dev_rd) begin
         if (dev_sel == 4'd0) rd_cnt++;
         if (dev_sel == 4'd7) stat_rd++;
      end
   end

   // ---------------- shadow model ----------------
   logic [7:0]  sh_tf [1:7];
   logic [7:0]  sh_devctl;
   int          sh_rd, sh_stat, sh_wn, sh_strobes;
   logic [15:0] sh_wlog [0:63];
   int          nchk = 0, nfail = 0;

   function automatic logic [15:0] sw16(logic [15:0] v);
      return {v[7:0], v[15:8]};
   endfunction
   function automatic logic [31:0] sw32(logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic push_log(input logic [15:0] v);
      if (sh_wn < 64) sh_wlog[sh_wn] = v;
      sh_wn++;
   endtask

   task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic w,
                         input logic [31:0] wd, input logic b, input string tag);
      int          idx;
      logic [31:0] exp;
      logic [31:0] s;
      logic [15:0] h;
      idx = int'(a[11:4]);
      exp = 32'h0;
      case (sz)
         2'd0: begin
            if (idx >= 1 && idx <= 7) begin
               sh_strobes++;
               if (w) sh_tf[idx] = wd[7:0];
               else begin exp = {24'h0, sh_tf[idx]}; if (idx == 7) sh_stat++; end
            end else if (idx == 8 || idx == 22) begin
               sh_strobes++;
               if (w) sh_devctl = wd[7:0];
               else exp = {24'h0, sh_tf[7]};
            end else if (!w) exp = 32'h0000_00FF;
         end
         2'd1: begin
            if (idx == 0) begin
               sh_strobes++;
               if (w) push_log(b ? sw16(wd[15:0]) : wd[15:0]);
               else begin h = dval(sh_rd); sh_rd++; exp = {16'h0, b ? sw16(h) : h}; end
            end else if (!w) exp = 32'h0000_FFFF;
         end
         2'd2: begin
            if (idx == 0) begin
               sh_strobes += 2;
               if (w) begin
                  s = b ? sw32(wd) : wd;
                  push_log(s[15:0]); push_log(s[31:16]);
               end else begin
                  s = {dval(sh_rd + 1), dval(sh_rd)}; sh_rd += 2;
                  exp = b ? sw32(s) : s;
               end
            end else if (!w) exp = 32'hFFFF_FFFF;
         end
         default: if (!w) exp = 32'hFFFF_FFFF;
      endcase
      @(negedge clk);
      addr = a; size = sz; we = w; wdata = wd; host_be = b; req = 1'b1;
      @(negedge clk);
      req = 1'b0; addr = $urandom; wdata = $urandom; host_be = $urandom;
      chk(ready === 1'b1, tag, "ready pulse (R9)", {31'h0, ready}, 32'h1);
      chk(rdata === exp, tag, "read data", rdata, exp);
      @(negedge clk);
      chk(ready === 1'b0 && rdata === 32'h0, tag, "idle after pulse (R9)", rdata, 32'h0);
      compare_state(tag);
   endtask

   task automatic compare_state(input string tag);
      bit ok;
      ok = 1;
      for (int i = 1; i <= 7; i++) if (tf[i] !== sh_tf[i]) ok = 0;
      chk(ok, tag, "task-file contents", 32'(tf[1]), 32'(sh_tf[1]));
      chk(devctl === sh_devctl, tag, "device control", 32'(devctl), 32'(sh_devctl));
      chk(strobes == sh_strobes, tag, "strobe count", 32'(strobes), 32'(sh_strobes));
      chk(rd_cnt == sh_rd && stat_rd == sh_stat, tag, "read side effects",
          32'(rd_cnt * 256 + stat_rd), 32'(sh_rd * 256 + sh_stat));
      ok = (wlog_n == sh_wn);
      for (int i = 0; i < 64; i++) if (i < sh_wn && wlog_d[i] !== sh_wlog[i]) ok = 0;
      chk(ok, tag, "data-port write log", 32'(wlog_n), 32'(sh_wn));
   endtask

   function automatic string tag_of(logic [31:0] a, logic [1:0] sz, logic b);
      int idx;
      idx = int'(a[11:4]);
      if (sz == 2'd0) begin
         if (idx >= 1 && idx <= 7) return "R1/R2";
         if (idx == 8 || idx == 22) return "R1/R3";
         return "R4";
      end
      if (sz == 2'd3 || idx != 0) return "R5";
      if (b) return "R8";
      return (sz == 2'd1) ? "R6" : "R7";
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int first;
      void'($urandom(32'd20240611));
      for (int i = 1; i <= 7; i++) sh_tf[i] = 8'(8'h10 * i + i);
      sh_devctl = 8'h00; sh_rd = 0; sh_stat = 0; sh_wn = 0; sh_strobes = 0;

      // R10: reset state, with a request held during reset
      @(negedge clk);
      addr = 32'h0; size = 2'd2; we = 1'b1; wdata = 32'hA5A5_5A5A; req = 1'b1;
      repeat (3) @(negedge clk);
      chk(ready === 1'b0 && rdata === 32'h0, "R10", "outputs in reset", rdata, 32'h0);
      chk(rst_strobes == 0, "R10", "strobes in reset", 32'(rst_strobes), 32'h0);
      req = 1'b0; rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(ready === 1'b0, "R10", "no late pulse after reset", {31'h0, ready}, 32'h0);
      compare_state("R10");

      // R1: high and low address bits ignored, alias control slots
      access(32'hFFFF_F03C, 2'd0, 1'b0, 32'h0, 1'b0, "R1");
      access(32'h1234_5165, 2'd0, 1'b1, 32'h0000_00C3, 1'b0, "R3");
      access(32'h0000_0080, 2'd0, 1'b0, 32'h0, 1'b0, "R3");
      access(32'h0000_0070, 2'd0, 1'b0, 32'h0, 1'b0, "R3");
      access(32'h8000_0000, 2'd0, 1'b0, 32'h0, 1'b0, "R4");
      access(32'h0000_0090, 2'd1, 1'b0, 32'h0, 1'b0, "R5");
      access(32'h0000_0010, 2'd2, 1'b1, 32'h1111_2222, 1'b0, "R5");
      access(32'h0000_0004, 2'd3, 1'b0, 32'h0, 1'b0, "R5");

      // R7: low half first, halves in consecutive cycles
      first = wlog_n;
      access(32'h0000_000C, 2'd2, 1'b1, 32'h1122_3344, 1'b0, "R7");
      chk(wlog_d[first] === 16'h3344 && wlog_d[first+1] === 16'h1122, "R7",
          "half order", {wlog_d[first], wlog_d[first+1]}, 32'h3344_1122);
      chk(wlog_c[first+1] - wlog_c[first] == 1, "R7", "half spacing",
          32'(wlog_c[first+1] - wlog_c[first]), 32'h1);
      access(32'h0000_0000, 2'd2, 1'b1, 32'h1122_3344, 1'b1, "R8");
      access(32'h0000_0000, 2'd1, 1'b1, 32'h0000_ABCD, 1'b1, "R8");
      access(32'h0000_0000, 2'd2, 1'b0, 32'h0, 1'b1, "R8");
      access(32'h0000_0000, 2'd1, 1'b0, 32'h0, 1'b0, "R6");

      // R1 plus random mix over all classes
      for (int n = 0; n < 400; n++) begin
         logic [31:0] a;
         logic [7:0]  ix;
         logic [1:0]  sz;
         logic        w, b;
         case ($urandom % 6)
            0: ix = 8'd0;
            1, 2: ix = 8'($urandom_range(1, 7));
            3: ix = ($urandom % 2) ? 8'd8 : 8'd22;
            default: ix = 8'($urandom);
         endcase
         a  = {20'($urandom), ix, 4'($urandom)};
         sz = 2'($urandom);
         w  = 1'($urandom);
         b  = 1'($urandom);
         access(a, sz, w, $urandom, b, tag_of(a, sz, b));
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule